// File: doc/BRIEF.md
# One-Wire Byte Transfer Sequencer

This block moves one whole byte over a one-wire bus by driving a separate time-slot engine. A transfer is launched with a start strobe, an operation code and a data byte. The block issues eight slot requests, least-significant bit first. Each request says whether the engine must run a short-low slot (a write-1, which also samples the line) or a long-low slot (a write-0). The block assembles what the engine samples into a result byte. Three operations exist. Write only sends data. Read sends eight sampling slots and collects the line. Touch sends the data and keeps the sampled level wherever a 1 was sent.

Devices that draw power from the bus during conversions need a strong pull-up after certain writes. A duration register, in milliseconds, holds a one-shot request. Just before the last slot of a write or touch, a nonzero request is latched and the register is cleared. Once the last slot has finished, the block waits the latched number of milliseconds. It counts a microsecond tick input to do so. During that wait it drives the strong-pullup enable when the feature is enabled, and otherwise it simply waits. The done pulse comes only after the wait, with the pull-up already released.

Top module: `owb_xfer`

## Requirements
- R1: After reset, busy, done, slot_req and spu_en are 0 and rd_byte is 0x00.
- R2: op encodes 2'b00 write, 2'b01 read and 2'b10 touch. A start with op 2'b11, or any start while busy is 1, is ignored.
- R3: Slot k of a transfer (k = 0..7) carries bit k of the latched data byte on slot_val, where 1 requests a short-low sampling slot and 0 a long-low slot.
- R4: A read sets slot_val to 1 for all eight slots. rd_byte bit k becomes the slot_rd level returned with the acknowledge of slot k.
- R5: A touch sets rd_byte bit k to the slot_rd sample of slot k where data bit k is 1, and to 0 where data bit k is 0.
- R6: A write leaves rd_byte unchanged.
- R7: slot_req stays high with slot_val stable until slot_ack. The next slot is requested in the cycle after the acknowledge.
- R8: The pull-up request is consumed on the acknowledge of slot 6 of a write or touch. A read neither uses nor clears it.
- R9: With pu_feature_en at 1 and a consumed request of N ms, spu_en is high for exactly N*US_PER_MS us_tick pulses after the last slot, and done follows.
- R10: With pu_feature_en at 0, the same N*US_PER_MS tick wait occurs with spu_en held low.
- R11: A consumed request reads as zero afterwards, so the next write has no wait. Writing 0 through pu_wr cancels a pending request.
- R12: spu_en is never high while slot_req is high or while done is high.
- R13: With no wait, done is a one-cycle pulse in the cycle after the last acknowledge. busy is 0 in the cycle after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a transfer (idle only) |
| op | input | 2 | Operation: 00 write, 01 read, 10 touch |
| wr_byte | input | 8 | Data byte to send |
| pu_wr | input | 1 | Write strobe for the pull-up duration register |
| pu_ms | input | 8 | Pull-up duration in ms (0 cancels) |
| pu_feature_en | input | 1 | Strong pull-up hardware present and enabled |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| slot_ack | input | 1 | Slot engine finished the current slot |
| slot_rd | input | 1 | Line level sampled in the finished slot |
| slot_req | output | 1 | Slot request to the slot engine |
| slot_val | output | 1 | Slot kind: 1 short-low/sample, 0 long-low |
| rd_byte | output | 8 | Result byte of the last read or touch |
| done | output | 1 | Transfer complete pulse |
| busy | output | 1 | Transfer in progress |
| spu_en | output | 1 | Strong pull-up enable |

## Verification
The next slot request is visible one cycle after the acknowledge that retires the current slot. So the bench plays the slot engine at falling edges and checks slot_val in the first cycle of each request, then again across a random acknowledge latency. rd_byte is due in the same cycle as done. With no pull-up wait, that is one cycle after the eighth acknowledge. The wait cannot be pinned to a cycle, so the bench counts us_tick pulses from the cycle after the last acknowledge up to done, and separately counts those seen while spu_en is high, and compares both to the duration its own register model expects. busy is checked one cycle after done.

// File: rtl/owb_pkg.sv
package owb_pkg;

    typedef enum logic [1:0] {
        OWB_WRITE = 2'b00,
        OWB_READ  = 2'b01,
        OWB_TOUCH = 2'b10,
        OWB_NONE  = 2'b11
    } owb_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SLOT,
        ST_HOLD,
        ST_DONE
    } owb_state_e;

    function automatic logic op_is_valid(owb_op_e op);
        return op != OWB_NONE;
    endfunction

    // operations that drive data onto the bus and may need a pull-up after
    function automatic logic op_sends(owb_op_e op);
        return (op == OWB_WRITE) || (op == OWB_TOUCH);
    endfunction

    // operations whose sampled byte is published
    function automatic logic op_returns(owb_op_e op);
        return (op == OWB_READ) || (op == OWB_TOUCH);
    endfunction

    // slot kind: 1 = short low pulse with sample, 0 = long low pulse
    function automatic logic slot_kind(owb_op_e op, logic dbit);
        return (op == OWB_READ) ? 1'b1 : dbit;
    endfunction

    function automatic logic captured(owb_op_e op, logic dbit, logic smp);
        case (op)
            OWB_READ:  return smp;
            OWB_TOUCH: return dbit & smp;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/owb_pullup_req.sv
module owb_pullup_req #(
    parameter int DUR_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [DUR_W-1:0] wr_dur,
    input  logic             consume,
    output logic [DUR_W-1:0] dur_q
);
    // a register write in the same cycle as consumption wins
    always_ff @(posedge clk) begin
        if (rst)
            dur_q <= '0;
        else if (wr_en)
            dur_q <= wr_dur;
        else if (consume)
            dur_q <= '0;
    end
endmodule

// File: rtl/owb_ms_timer.sv
module owb_ms_timer #(
    parameter int DUR_W     = 8,
    parameter int US_PER_MS = 1000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [DUR_W-1:0] load_ms,
    input  logic             us_tick,
    output logic             active,
    output logic             expire
);
    localparam int SUB_W = (US_PER_MS > 2) ? $clog2(US_PER_MS) : 1;
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(US_PER_MS - 1);

    logic [SUB_W-1:0] sub_q;
    logic [DUR_W-1:0] ms_q;
    logic             run_q;
    logic             ms_wrap;

    assign ms_wrap = run_q && us_tick && (sub_q == SUB_LAST);
    assign expire  = ms_wrap && (ms_q == DUR_W'(1));
    assign active  = run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sub_q <= '0;
            ms_q  <= '0;
            run_q <= 1'b0;
        end else if (load) begin
            sub_q <= '0;
            ms_q  <= load_ms;
            run_q <= (load_ms != '0);
        end else if (run_q && us_tick) begin
            if (ms_wrap) begin
                sub_q <= '0;
                ms_q  <= ms_q - DUR_W'(1);
                if (ms_q == DUR_W'(1))
                    run_q <= 1'b0;
            end else begin
                sub_q <= sub_q + SUB_W'(1);
            end
        end
    end
endmodule

// File: rtl/owb_byte_seq.sv
module owb_byte_seq
    import owb_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int DUR_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  owb_op_e           op_in,
    input  logic [BYTE_W-1:0] data_in,
    input  logic              slot_ack,
    input  logic              slot_rd,
    input  logic [DUR_W-1:0]  pu_dur,
    input  logic              hold_expire,
    output logic              slot_req,
    output logic              slot_val,
    output logic              arm,
    output logic              hold_load,
    output logic [DUR_W-1:0]  hold_ms,
    output logic              done,
    output logic              busy,
    output logic [BYTE_W-1:0] result
);
    localparam int IDX_W = $clog2(BYTE_W);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(BYTE_W - 1);
    localparam logic [IDX_W-1:0] IDX_ARM  = IDX_W'(BYTE_W - 2);

    owb_state_e        state_q;
    owb_op_e           op_q;
    logic [BYTE_W-1:0] sh_q;
    logic [BYTE_W-1:0] acc_q;
    logic [BYTE_W-1:0] acc_nx;
    logic [IDX_W-1:0]  idx_q;
    logic [DUR_W-1:0]  armed_q;
    logic [BYTE_W-1:0] res_q;
    logic              last_ack;

    assign acc_nx    = {captured(op_q, sh_q[0], slot_rd), acc_q[BYTE_W-1:1]};
    assign last_ack  = (state_q == ST_SLOT) && slot_ack && (idx_q == IDX_LAST);
    assign arm       = (state_q == ST_SLOT) && slot_ack && (idx_q == IDX_ARM)
                       && op_sends(op_q);
    assign hold_load = last_ack && (armed_q != '0);
    assign hold_ms   = armed_q;

    assign slot_req = (state_q == ST_SLOT);
    assign slot_val = slot_kind(op_q, sh_q[0]);
    assign done     = (state_q == ST_DONE);
    assign busy     = (state_q != ST_IDLE);
    assign result   = res_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            op_q    <= OWB_WRITE;
            sh_q    <= '0;
            acc_q   <= '0;
            idx_q   <= '0;
            armed_q <= '0;
            res_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start && op_is_valid(op_in)) begin
                        op_q    <= op_in;
                        sh_q    <= data_in;
                        acc_q   <= '0;
                        idx_q   <= '0;
                        armed_q <= '0;
                        state_q <= ST_SLOT;
                    end
                end
                ST_SLOT: begin
                    if (slot_ack) begin
                        acc_q <= acc_nx;
                        sh_q  <= sh_q >> 1;
                        if (arm)
                            armed_q <= pu_dur;
                        if (idx_q == IDX_LAST) begin
                            if (op_returns(op_q))
                                res_q <= acc_nx;
                            state_q <= (armed_q != '0) ? ST_HOLD : ST_DONE;
                        end else begin
                            idx_q <= idx_q + IDX_W'(1);
                        end
                    end
                end
                ST_HOLD: begin
                    if (hold_expire)
                        state_q <= ST_DONE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/owb_xfer.sv
module owb_xfer
    import owb_pkg::*;
#(
    parameter int BYTE_W    = 8,
    parameter int DUR_W     = 8,
    parameter int US_PER_MS = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [1:0]        op,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic              pu_wr,
    input  logic [DUR_W-1:0]  pu_ms,
    input  logic              pu_feature_en,
    input  logic              us_tick,
    input  logic              slot_ack,
    input  logic              slot_rd,
    output logic              slot_req,
    output logic              slot_val,
    output logic [BYTE_W-1:0] rd_byte,
    output logic              done,
    output logic              busy,
    output logic              spu_en
);
    logic [DUR_W-1:0] pu_dur;
    logic             arm;
    logic             hold_load;
    logic [DUR_W-1:0] hold_ms;
    logic             hold_active;
    logic             hold_expire;

    owb_pullup_req #(.DUR_W(DUR_W)) u_req (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (pu_wr),
        .wr_dur  (pu_ms),
        .consume (arm),
        .dur_q   (pu_dur)
    );

    owb_byte_seq #(.BYTE_W(BYTE_W), .DUR_W(DUR_W)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .op_in       (owb_op_e'(op)),
        .data_in     (wr_byte),
        .slot_ack    (slot_ack),
        .slot_rd     (slot_rd),
        .pu_dur      (pu_dur),
        .hold_expire (hold_expire),
        .slot_req    (slot_req),
        .slot_val    (slot_val),
        .arm         (arm),
        .hold_load   (hold_load),
        .hold_ms     (hold_ms),
        .done        (done),
        .busy        (busy),
        .result      (rd_byte)
    );

    owb_ms_timer #(.DUR_W(DUR_W), .US_PER_MS(US_PER_MS)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .load    (hold_load),
        .load_ms (hold_ms),
        .us_tick (us_tick),
        .active  (hold_active),
        .expire  (hold_expire)
    );

    // pull-up only while the timer runs, which is after the last slot
    assign spu_en = hold_active && pu_feature_en;
endmodule

// File: rtl/owb_xfer_chk.sv
module owb_xfer_chk (
    input logic clk,
    input logic rst,
    input logic slot_req,
    input logic slot_val,
    input logic slot_ack,
    input logic done,
    input logic busy,
    input logic spu_en
);
    AST_SPU_NOT_IN_SLOT: assert property (@(posedge clk) disable iff (rst)
        spu_en |-> !slot_req);                                  // R12
    AST_SPU_OFF_AT_DONE: assert property (@(posedge clk) disable iff (rst)
        done |-> !spu_en);                                      // R12
    AST_SLOT_HELD: assert property (@(posedge clk) disable iff (rst)
        (slot_req && !slot_ack) |=> (slot_req && $stable(slot_val))); // R7
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));                             // R13
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!slot_req && !spu_en && !done));             // R1
endmodule

bind owb_xfer owb_xfer_chk u_owb_chk (
    .clk      (clk),
    .rst      (rst),
    .slot_req (slot_req),
    .slot_val (slot_val),
    .slot_ack (slot_ack),
    .done     (done),
    .busy     (busy),
    .spu_en   (spu_en)
);

// File: tb/tb_owb_xfer.sv
module tb_owb_xfer;
    localparam int UPM = 1000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [1:0] op = 2'b00;
    logic [7:0] wr_byte = 8'h00;
    logic       pu_wr = 1'b0;
    logic [7:0] pu_ms = 8'h00;
    logic       pu_feature_en = 1'b0;
    logic       us_tick = 1'b0;
    logic       slot_ack = 1'b0;
    logic       slot_rd = 1'b0;
    logic       slot_req, slot_val, done, busy, spu_en;
    logic [7:0] rd_byte;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] m_rd  = 8'h00;
    int         m_dur = 0;

    always #10 clk = ~clk;

    owb_xfer dut (
        .clk(clk), .rst(rst), .start(start), .op(op), .wr_byte(wr_byte),
        .pu_wr(pu_wr), .pu_ms(pu_ms), .pu_feature_en(pu_feature_en),
        .us_tick(us_tick), .slot_ack(slot_ack), .slot_rd(slot_rd),
        .slot_req(slot_req), .slot_val(slot_val), .rd_byte(rd_byte),
        .done(done), .busy(busy), .spu_en(spu_en)
    );

    // microsecond tick every other cycle, changing away from both edges
    initial begin
        forever begin
            @(posedge clk);
            #5 us_tick = ~us_tick;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_result(input logic [1:0] o, input logic [7:0] d,
                                              input logic [7:0] pat, input logic [7:0] prev);
        case (o)
            2'b01:   return pat;
            2'b10:   return d & pat;
            default: return prev;
        endcase
    endfunction

    task automatic set_pu(input int ms);
        @(negedge clk);
        pu_wr = 1'b1; pu_ms = 8'(ms);
        @(negedge clk);
        pu_wr = 1'b0;
        m_dur = ms;
    endtask

    task automatic run_op(input logic [1:0] o, input logic [7:0] d, input logic [7:0] pat,
                          input bit mid_start);
        int hold, spu_t, wait_t, guard;
        bit bad_lvl, bad_hold, bad_spu;
        logic exp_lvl;
        hold = 0; spu_t = 0; wait_t = 0;
        bad_lvl = 0; bad_hold = 0; bad_spu = 0;
        if (o != 2'b01) begin
            hold = m_dur;
            m_dur = 0;
        end
        @(negedge clk);
        start = 1'b1; op = o; wr_byte = d;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 8; i++) begin
            guard = 0;
            while (!slot_req && guard < 50) begin
                @(negedge clk);
                guard++;
            end
            exp_lvl = (o == 2'b01) ? 1'b1 : d[i];
            if (slot_val !== exp_lvl || !slot_req) bad_lvl = 1;
            if (spu_en) bad_spu = 1;
            if (mid_start && i == 3) begin
                start = 1'b1; op = 2'b01; wr_byte = ~d;
                @(negedge clk);
                start = 1'b0; op = o; wr_byte = d;
                if (!slot_req || slot_val !== exp_lvl) bad_hold = 1;
            end
            for (int w = 0; w < int'($urandom % 4); w++) begin
                @(negedge clk);
                if (!slot_req || slot_val !== exp_lvl) bad_hold = 1;
                if (spu_en) bad_spu = 1;
            end
            slot_ack = 1'b1; slot_rd = pat[i];
            @(negedge clk);
            slot_ack = 1'b0; slot_rd = 1'b0;
        end
        guard = 0;
        while (!done && guard < 20000) begin
            if (us_tick) begin
                wait_t++;
                if (spu_en) spu_t++;
            end
            if (slot_req) bad_spu = 1;
            @(negedge clk);
            guard++;
        end
        chk(slot_val === slot_val && !bad_lvl, "R3/R4 slot level per bit", bad_lvl, 0);
        chk(!bad_hold, "R7 request held until ack", bad_hold, 0);
        chk(done === 1'b1, "R13 done reached", done, 1);
        chk(!spu_en && !bad_spu, "R12 spu_en off in slots and at done", spu_en | bad_spu, 0);
        chk(wait_t == hold * UPM, "R9/R10/R11 wait ticks", wait_t, hold * UPM);
        chk(spu_t == (pu_feature_en ? hold * UPM : 0), "R9/R10 spu ticks",
            spu_t, pu_feature_en ? hold * UPM : 0);
        m_rd = exp_result(o, d, pat, m_rd);
        chk(rd_byte == m_rd, (o == 2'b10) ? "R5 touch result" :
            (o == 2'b01) ? "R4 read result" : "R6 write keeps result", rd_byte, m_rd);
        @(negedge clk);
        chk(!done && !busy, "R13 done single pulse then idle", {done, busy}, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(!busy && !done && !slot_req && !spu_en && rd_byte == 8'h00, "R1 reset state",
            {busy, done, slot_req, spu_en}, 0);

        // R4 read, R3 LSB first
        run_op(2'b01, 8'h00, 8'hA5, 0);
        // R6 write keeps result
        run_op(2'b00, 8'h3C, 8'hFF, 0);
        // R5 touch
        run_op(2'b10, 8'hF0, 8'h5A, 0);
        // R2 start while busy ignored
        run_op(2'b10, 8'h96, 8'hFF, 1);

        // R2 op 11 ignored
        @(negedge clk);
        start = 1'b1; op = 2'b11; wr_byte = 8'h55;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        chk(!busy && !slot_req, "R2 op 11 ignored", busy, 0);

        // R9 pull-up with feature, then R11 consumed
        pu_feature_en = 1'b1;
        set_pu(2);
        run_op(2'b00, 8'h81, 8'h00, 0);
        run_op(2'b00, 8'h44, 8'h00, 0);
        // R10 feature disabled: plain wait
        pu_feature_en = 1'b0;
        set_pu(1);
        run_op(2'b10, 8'hC3, 8'h0F, 0);
        // R8 read does not consume the request
        pu_feature_en = 1'b1;
        set_pu(1);
        run_op(2'b01, 8'h00, 8'h3E, 0);
        run_op(2'b00, 8'h7E, 8'h00, 0);
        // R11 writing zero cancels
        set_pu(2);
        set_pu(0);
        run_op(2'b00, 8'h11, 8'h00, 0);

        // constrained random mix
        void'($urandom(32'd1207));
        for (int k = 0; k < 20; k++) begin
            logic [1:0] ro;
            ro = 2'($urandom % 3);
            pu_feature_en = 1'($urandom % 2);
            if ($urandom % 3 == 0) set_pu(int'($urandom % 2));
            run_op(ro, 8'($urandom), 8'($urandom), ($urandom % 5) == 0);
        end

        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule